// File: doc/BRIEF.md
# Interrupt Pin Conditioning Router

This block sits between two multi-role interrupt pins and the interrupt controller of a small microcontroller. Every asynchronous pin passes through a two-stage synchronizer. Each of three request channels then goes through a detector that is either level-following or edge-latching, and a per-channel mask gates the result toward the controller. Channel A comes from the first shared pin, channel B from the second shared pin, and channel C from a dedicated request pin.

The CPU can repurpose the two shared pins through a small write-only configuration port. In cascade mode a pin becomes an active-low acknowledge output, pulsed by a strobe from the controller. In slave mode the second pin carries an outgoing request to an external master. In demodulation mode the first pin's level feeds timer input 0 and channel A. Its complement feeds timer input 1 and channel C. The level is also mirrored into a port-data bit, and the dedicated timer and request pins are ignored.

Top module: `irq_pin_router`

## Requirements
- R1: A rising pin level reaches a level-mode pending output only after two rising clock edges. After one edge it still reads 0.
- R2: A channel whose trigger bit is 0 (level mode) reports its synchronized request level directly and drops it when the pin falls.
- R3: A channel whose trigger bit is 1 (edge mode) latches a rising request and holds it after the pin falls. Only a one-cycle pulse on that channel's bit of `eoi_i` clears it.
- R4: Mask bit i set forces `pend_o[i]` to 0 without stopping the edge latch. Clearing the mask then shows a pending request captured while masked.
- R5: With mode bit 0 (cascade A) set, `pin_a_oe` is 1. `pin_a_o` goes low for exactly the one cycle after each `ack0_stb_i` pulse, and channel A reads 0. With cascade A clear, `ack0_stb_i` leaves `pin_a_o` high.
- R6: With mode bit 1 (cascade B) set, `pin_b_oe` is 1. `pin_b_o` goes low for exactly the one cycle after each `ack1_stb_i` pulse, and channel B reads 0.
- R7: With mode bit 2 (slave) set and cascade B clear, `pin_b_oe` is 1 and `pin_b_o` equals `slave_req_i` delayed one cycle. Channel B reads 0. Cascade B takes priority over slave.
- R8: With mode bit 3 (demodulation) set and cascade A clear, `tmr0_o` and channel A follow the synchronized `pin_a_i`, and `tmr1_o` and channel C follow its inverse. `tmr0_pin_i`, `tmr1_pin_i` and `int4_pin_i` have no effect.
- R9: `pio_lvl_o` equals the synchronized `pin_a_i` level while demodulation is in effect, and 0 otherwise.
- R10: Outside demodulation, `tmr0_o` and `tmr1_o` follow the synchronized dedicated timer pins, and channel C follows `int4_pin_i`.
- R11: Configuration writes select by `cfg_addr`: 0 for the mode bits, 1 for trigger bits [2:0] (1 = edge), 2 for mask bits [2:0] (1 = masked). After reset all are 0: level mode, unmasked, and all pins are inputs.
- R12: A pin not acting as an output has its enable at 0 and its output value at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 4 | Configuration write data |
| pin_a_i | input | 1 | Shared pin A input level |
| pin_a_o | output | 1 | Shared pin A output value |
| pin_a_oe | output | 1 | Shared pin A output enable |
| pin_b_i | input | 1 | Shared pin B input level |
| pin_b_o | output | 1 | Shared pin B output value |
| pin_b_oe | output | 1 | Shared pin B output enable |
| tmr0_pin_i | input | 1 | Dedicated timer input 0 pin |
| tmr1_pin_i | input | 1 | Dedicated timer input 1 pin |
| int4_pin_i | input | 1 | Dedicated request pin for channel C |
| ack0_stb_i | input | 1 | Acknowledge strobe for channel A cascade |
| ack1_stb_i | input | 1 | Acknowledge strobe for channel B cascade |
| slave_req_i | input | 1 | Request to forward to an external master |
| eoi_i | input | 3 | Per-channel end-of-interrupt clear strobes |
| pend_o | output | 3 | Masked pending requests, channels A, B, C |
| tmr0_o | output | 1 | Conditioned timer input 0 |
| tmr1_o | output | 1 | Conditioned timer input 1 |
| pio_lvl_o | output | 1 | Pin A level for the port-data mirror bit |

## Verification
The hardest state to reach is an edge request captured behind a mask, which then has to surface only when the mask is lifted. The mask hides the latch, so the stimulus raises the pin while it is masked, drops the pin again, and only then clears the mask. The role overrides are also easy to miss, so every one of the sixteen mode combinations is swept against every pattern of the five input pins. This covers the case where cascade A and demodulation are both set, in which cascade must win.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int NCH    = 3;
  localparam int NPIN   = 5;
  localparam int MODE_W = 4;

  // synchronized pin vector positions
  localparam int P_A  = 0;
  localparam int P_B  = 1;
  localparam int P_I4 = 2;
  localparam int P_T0 = 3;
  localparam int P_T1 = 4;

  typedef enum logic [1:0] {
    CFG_MODE = 2'd0,
    CFG_TRIG = 2'd1,
    CFG_MASK = 2'd2,
    CFG_RSVD = 2'd3
  } cfg_addr_e;

  typedef struct packed {
    logic demod;
    logic slave;
    logic casc1;
    logic casc0;
  } mode_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[k] <= '0;
        else        stage_q[k] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[k] <= '0;
        else        stage_q[k] <= stage_q[k-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_pin_pkg::*;
(
  input  mode_t            mode_i,
  input  logic [NPIN-1:0]  sync_i,
  output logic [NCH-1:0]   raw_o,
  output logic             tmr0_o,
  output logic             tmr1_o,
  output logic             pio_lvl_o,
  output logic             demod_eff_o
);
  // cascade on pin A owns the pin, so it overrides demodulation
  function automatic logic demod_active(mode_t m);
    return m.demod & ~m.casc0;
  endfunction

  function automatic logic pin_b_is_out(mode_t m);
    return m.casc1 | m.slave;
  endfunction

  function automatic logic [NCH-1:0] req_mux(mode_t m, logic [NPIN-1:0] s);
    logic [NCH-1:0] r;
    r[0] = m.casc0 ? 1'b0 : s[P_A];
    r[1] = pin_b_is_out(m) ? 1'b0 : s[P_B];
    r[2] = demod_active(m) ? ~s[P_A] : s[P_I4];
    return r;
  endfunction

  assign demod_eff_o = demod_active(mode_i);
  assign raw_o       = req_mux(mode_i, sync_i);
  assign tmr0_o      = demod_eff_o ? sync_i[P_A]  : sync_i[P_T0];
  assign tmr1_o      = demod_eff_o ? ~sync_i[P_A] : sync_i[P_T1];
  assign pio_lvl_o   = demod_eff_o & sync_i[P_A];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] edge_sel_i,
  input  logic [N-1:0] eoi_i,
  output logic [N-1:0] det_o
);
  logic [N-1:0] raw_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;

  assign rise = raw_i & ~raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pend_q[i] <= 1'b0;
      else if (!edge_sel_i[i]) pend_q[i] <= 1'b0;
      else if (rise[i])        pend_q[i] <= 1'b1;
      else if (eoi_i[i])       pend_q[i] <= 1'b0;
    end

    assign det_o[i] = edge_sel_i[i] ? pend_q[i] : raw_i[i];

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel_i[i] && pend_q[i] && !eoi_i[i]) |=> pend_q[i]); // R3
    AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel_i[i] && eoi_i[i] && !rise[i]) |=> !pend_q[i]); // R3
    AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel_i[i] && rise[i]) |=> pend_q[i]); // R3
  end
endmodule

// File: rtl/irq_ack_drv.sv
module irq_ack_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic casc0_i,
  input  logic casc1_i,
  input  logic slave_i,
  input  logic ack0_stb_i,
  input  logic ack1_stb_i,
  input  logic slave_req_i,
  output logic pin_a_o,
  output logic pin_a_oe,
  output logic pin_b_o,
  output logic pin_b_oe
);
  logic a_ack_n_q;
  logic b_ack_n_q;
  logic irq_q;
  logic a_fire;
  logic b_fire;

  assign a_fire = ack0_stb_i & casc0_i;
  assign b_fire = ack1_stb_i & casc1_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_ack_n_q <= 1'b1;
      b_ack_n_q <= 1'b1;
      irq_q     <= 1'b0;
    end else begin
      a_ack_n_q <= ~a_fire;
      b_ack_n_q <= ~b_fire;
      irq_q     <= slave_req_i;
    end
  end

  assign pin_a_oe = casc0_i;
  assign pin_a_o  = casc0_i ? a_ack_n_q : 1'b1;
  assign pin_b_oe = casc1_i | slave_i;
  assign pin_b_o  = casc1_i ? b_ack_n_q : (slave_i ? irq_q : 1'b1);

  AST_ACK_A_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_ack_n_q && !a_fire) |=> a_ack_n_q); // R5
  AST_ACK_B_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_ack_n_q && !b_fire) |=> b_ack_n_q); // R6
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [MODE_W-1:0] cfg_wdata,
  input  logic              pin_a_i,
  output logic              pin_a_o,
  output logic              pin_a_oe,
  input  logic              pin_b_i,
  output logic              pin_b_o,
  output logic              pin_b_oe,
  input  logic              tmr0_pin_i,
  input  logic              tmr1_pin_i,
  input  logic              int4_pin_i,
  input  logic              ack0_stb_i,
  input  logic              ack1_stb_i,
  input  logic              slave_req_i,
  input  logic [NCH-1:0]    eoi_i,
  output logic [NCH-1:0]    pend_o,
  output logic              tmr0_o,
  output logic              tmr1_o,
  output logic              pio_lvl_o
);
  mode_t           mode_q;
  logic [NCH-1:0]  trig_q;
  logic [NCH-1:0]  mask_q;
  logic [NPIN-1:0] pins_async;
  logic [NPIN-1:0] pins_sync;
  logic [NCH-1:0]  raw;
  logic [NCH-1:0]  det;
  logic            demod_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      trig_q <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr_e'(cfg_addr))
        CFG_MODE: mode_q <= mode_t'(cfg_wdata);
        CFG_TRIG: trig_q <= cfg_wdata[NCH-1:0];
        CFG_MASK: mask_q <= cfg_wdata[NCH-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    pins_async       = '0;
    pins_async[P_A]  = pin_a_i;
    pins_async[P_B]  = pin_b_i;
    pins_async[P_I4] = int4_pin_i;
    pins_async[P_T0] = tmr0_pin_i;
    pins_async[P_T1] = tmr1_pin_i;
  end

  irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_async),
    .q_o   (pins_sync)
  );

  irq_route u_route (
    .mode_i      (mode_q),
    .sync_i      (pins_sync),
    .raw_o       (raw),
    .tmr0_o      (tmr0_o),
    .tmr1_o      (tmr1_o),
    .pio_lvl_o   (pio_lvl_o),
    .demod_eff_o (demod_eff)
  );

  irq_detect #(.N(NCH)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_i      (raw),
    .edge_sel_i (trig_q),
    .eoi_i      (eoi_i),
    .det_o      (det)
  );

  assign pend_o = det & ~mask_q;

  irq_ack_drv u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .casc0_i     (mode_q.casc0),
    .casc1_i     (mode_q.casc1),
    .slave_i     (mode_q.slave),
    .ack0_stb_i  (ack0_stb_i),
    .ack1_stb_i  (ack1_stb_i),
    .slave_req_i (slave_req_i),
    .pin_a_o     (pin_a_o),
    .pin_a_oe    (pin_a_oe),
    .pin_b_o     (pin_b_o),
    .pin_b_oe    (pin_b_oe)
  );

  AST_PIN_A_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pin_a_oe |-> !raw[0]); // R5
  AST_PIN_B_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pin_b_oe |-> !raw[1]); // R7
  AST_IDLE_PIN_A_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_a_oe |-> pin_a_o); // R12
  AST_IDLE_PIN_B_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_b_oe |-> pin_b_o); // R12
  AST_DEMOD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    demod_eff |-> ((tmr0_o != tmr1_o) && (raw[2] == tmr1_o) && (pio_lvl_o == tmr0_o))); // R8
  AST_DEMOD_CASC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    demod_eff |-> !pin_a_oe); // R8
endmodule

// File: tb/sim_irq_pin_router.sv
module sim_irq_pin_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic       pin_a_i = 1'b0, pin_b_i = 1'b0;
  logic       tmr0_pin_i = 1'b0, tmr1_pin_i = 1'b0, int4_pin_i = 1'b0;
  logic       ack0_stb_i = 1'b0, ack1_stb_i = 1'b0, slave_req_i = 1'b0;
  logic [2:0] eoi_i = '0;
  logic       pin_a_o, pin_a_oe, pin_b_o, pin_b_oe;
  logic [2:0] pend_o;
  logic       tmr0_o, tmr1_o, pio_lvl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_pin_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pin_a_i(pin_a_i), .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe),
    .pin_b_i(pin_b_i), .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe),
    .tmr0_pin_i(tmr0_pin_i), .tmr1_pin_i(tmr1_pin_i), .int4_pin_i(int4_pin_i),
    .ack0_stb_i(ack0_stb_i), .ack1_stb_i(ack1_stb_i), .slave_req_i(slave_req_i),
    .eoi_i(eoi_i), .pend_o(pend_o), .tmr0_o(tmr0_o), .tmr1_o(tmr1_o), .pio_lvl_o(pio_lvl_o)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic set_pins(int p);
    pin_a_i    = p[0];
    pin_b_i    = p[1];
    int4_pin_i = p[2];
    tmr0_pin_i = p[3];
    tmr1_pin_i = p[4];
  endtask

  // expected {pend[2:0], tmr1, tmr0, pio, oe_a, out_a, oe_b, out_b}, level mode, unmasked, idle strobes
  function automatic logic [9:0] model(int m, int p);
    bit c0 = m[0], c1 = m[1], sl = m[2];
    bit dm = m[3] && !m[0];
    bit a = p[0], b = p[1], i4 = p[2], t0 = p[3], t1 = p[4];
    bit ra, rb, rc, eb_out, vb;
    ra = c0 ? 1'b0 : a;
    rb = (c1 || sl) ? 1'b0 : b;
    if (dm) rc = !a; else rc = i4;
    eb_out = c1 || sl;
    if (c1) vb = 1'b1; else if (sl) vb = 1'b0; else vb = 1'b1;
    return {rc, rb, ra, (dm ? !a : t1), (dm ? a : t0), (dm & a), c0, 1'b1, eb_out, vb};
  endfunction

  function automatic logic [9:0] observe();
    return {pend_o, tmr1_o, tmr0_o, pio_lvl_o, pin_a_oe, pin_a_o, pin_b_oe, pin_b_o};
  endfunction

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11 R12 reset state
    check("R11 reset outputs", 16'(observe()), 16'(10'b000_0_0_0_0_1_0_1));

    // R1 two-stage synchronizer latency in level mode
    pin_a_i = 1'b1;
    tick(1);
    check("R1 after one edge", 16'(pend_o), 16'd0);
    tick(1);
    check("R1 after two edges", 16'(pend_o), 16'd1);
    pin_a_i = 1'b0;
    tick(3);
    check("R2 level drop", 16'(pend_o), 16'd0);

    // R2 R5 R6 R7 R8 R9 R10 R12 sweep of all modes and pin patterns
    for (int m = 0; m < 16; m++) begin
      wr(2'd0, 4'(m));
      for (int p = 0; p < 32; p++) begin
        set_pins(p);
        tick(3);
        check($sformatf("R2 R5 R6 R7 R8 R9 R10 R12 mode=%0d pins=%0d", m, p),
              16'(observe()), 16'(model(m, p)));
      end
    end
    set_pins(0);
    wr(2'd0, 4'd0);

    // R4 mask sweep in level mode
    set_pins(7);
    tick(3);
    for (int k = 0; k < 8; k++) begin
      wr(2'd2, 4'(k));
      check($sformatf("R4 mask=%0d", k), 16'(pend_o), 16'((~k) & 7));
    end
    wr(2'd2, 4'd0);
    set_pins(0);
    tick(3);

    // R3 edge latch, hold and clear per channel
    wr(2'd1, 4'd7);
    for (int ch = 0; ch < 3; ch++) begin
      set_pins(1 << ch);
      tick(4);
      check($sformatf("R3 latch ch%0d", ch), 16'(pend_o), 16'(1 << ch));
      set_pins(0);
      tick(4);
      check($sformatf("R3 hold ch%0d", ch), 16'(pend_o), 16'(1 << ch));
      eoi_i = 3'(((1 << ch) ^ 7) & 7);
      tick(1);
      eoi_i = '0;
      check($sformatf("R3 other eoi ch%0d", ch), 16'(pend_o), 16'(1 << ch));
      eoi_i = 3'(1 << ch);
      tick(1);
      eoi_i = '0;
      check($sformatf("R3 clear ch%0d", ch), 16'(pend_o), 16'd0);
    end

    // R4 edge captured behind mask surfaces on unmask
    wr(2'd2, 4'd7);
    set_pins(2);
    tick(4);
    check("R4 masked edge hidden", 16'(pend_o), 16'd0);
    set_pins(0);
    tick(4);
    wr(2'd2, 4'd0);
    check("R4 unmask shows latch", 16'(pend_o), 16'd2);
    eoi_i = 3'd2; tick(1); eoi_i = '0;
    wr(2'd1, 4'd0);

    // R5 acknowledge pulse on pin A
    ack0_stb_i = 1'b1;
    tick(1);
    ack0_stb_i = 1'b0;
    check("R5 strobe without cascade", 16'({pin_a_oe, pin_a_o}), 16'b01);
    wr(2'd0, 4'b0001);
    ack0_stb_i = 1'b1;
    tick(1);
    ack0_stb_i = 1'b0;
    check("R5 ack low", 16'({pin_a_oe, pin_a_o}), 16'b10);
    tick(1);
    check("R5 ack released", 16'({pin_a_oe, pin_a_o}), 16'b11);

    // R6 acknowledge pulse on pin B, with slave also set (R7 priority)
    wr(2'd0, 4'b0110);
    slave_req_i = 1'b1;
    ack1_stb_i  = 1'b1;
    tick(1);
    ack1_stb_i = 1'b0;
    check("R6 ack low", 16'({pin_b_oe, pin_b_o}), 16'b10);
    tick(1);
    check("R6 R7 cascade over slave", 16'({pin_b_oe, pin_b_o}), 16'b11);

    // R7 slave request forwarded with one cycle delay
    wr(2'd0, 4'b0100);
    check("R7 slave request high", 16'({pin_b_oe, pin_b_o}), 16'b11);
    slave_req_i = 1'b0;
    check("R7 before edge", 16'(pin_b_o), 16'd1);
    tick(1);
    check("R7 request dropped", 16'(pin_b_o), 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule